// File: doc/BRIEF.md
# Threshold-Based Supply Voltage Step Controller

This block turns a windowed timing-error count into supply-voltage step requests for an adaptive voltage-scaling loop. An external error unit supplies a running count of detected errors for the current observation window and a one-cycle strobe when the window closes. The controller compares that count against programmable thresholds. It keeps a voltage code in units of 10 mV, ranging from 60 (0.60 V) to 110 (1.10 V). It emits one-cycle up or down pulses for the regulator to follow.

Two policies are supported. In the single-threshold policy, one limit decides both directions. In the double-threshold policy, a lower and an upper limit enclose a neutral band where the supply is left alone. A raise is taken on any cycle as soon as its condition holds, without waiting for the window to close. A raise that happens mid-window also asks the error unit to restart its window. A lowering is only taken at window close. After every step the controller stays busy for a settling time that depends on the chosen step size, and it makes no new decision until that time has passed.

Top module: `vstep_ctrl`

## Requirements
- R1: After reset, the voltage code is 110 and step_up, step_dn, busy and win_restart are all low.
- R2: With dbl_mode=0, a count strictly above thr_hi on any idle cycle produces a step_up pulse in the next cycle. A count equal to thr_hi produces no raise.
- R3: With dbl_mode=0, a win_done strobe with the count at or below thr_hi produces a step_dn pulse in the next cycle.
- R4: With dbl_mode=1, a count at or above thr_hi on any idle cycle produces a step_up pulse in the next cycle.
- R5: With dbl_mode=1, win_done with the count at or below thr_lo produces step_dn. A count strictly between thr_lo and thr_hi at win_done leaves the code and all pulses unchanged.
- R6: step_sel selects the step in code units: 0 gives 2 (20 mV), 1 gives 5, 2 gives 10 and 3 gives 25. The code changes only in the cycle that shows a step pulse.
- R7: After a step, busy stays high for 1, 2, 5 or 12 cycles for step_sel 0 to 3, starting with the pulse cycle. No step is issued while busy is high.
- R8: win_restart pulses together with step_up exactly when the raise was decided on a cycle without win_done.
- R9: The code never leaves the range 60 to 110. A step that would overshoot stops at the bound. A request made while the code is already at the bound is dropped: there is no pulse, no busy and no restart.
- R10: If the raise and lower conditions hold in the same cycle, the raise wins. step_up and step_dn are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_count | input | CNT_W | Running error count of the current window |
| win_done | input | 1 | One-cycle strobe at window close |
| dbl_mode | input | 1 | 0 single-threshold, 1 double-threshold policy |
| thr_hi | input | CNT_W | Raise threshold (also the lower threshold in single mode) |
| thr_lo | input | CNT_W | Lower threshold for the double policy |
| step_sel | input | 2 | Step size and settling selector |
| vcode | output | CODE_W | Voltage code in 10 mV units |
| step_up | output | 1 | One-cycle raise request |
| step_dn | output | 1 | One-cycle lower request |
| busy | output | 1 | Settling in progress, decisions held off |
| win_restart | output | 1 | Request to the error unit to restart its window |

## Verification
The assertions assume that win_done is a single-cycle strobe driven between clock edges. They also assume that step_sel is steady on the cycle that issues a step. They do not assume that the thresholds are ordered, because the raise-first rule covers a lower threshold above the upper one. The stimulus drives all inputs on the falling edge. It mostly keeps thr_lo at one fifth of thr_hi, as in typical settings. A directed case deliberately crosses the thresholds to exercise that priority rule.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

  localparam int LAT_W  = 4;
  localparam int STEP_W = 5;

  typedef enum logic {POL_SINGLE = 1'b0, POL_DOUBLE = 1'b1} policy_e;

  // step size in 10 mV code units
  function automatic logic [STEP_W-1:0] step_units(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd2;
      2'd1:    return 5'd5;
      2'd2:    return 5'd10;
      default: return 5'd25;
    endcase
  endfunction

  // regulator settling time in clock cycles
  function automatic logic [LAT_W-1:0] settle_cycles(input logic [1:0] sel);
    case (sel)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      2'd2:    return 4'd5;
      default: return 4'd12;
    endcase
  endfunction

endpackage

// File: rtl/vstep_decide.sv
module vstep_decide
  import vstep_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] err_count,
  input  logic             win_done,
  input  logic             dbl_mode,
  input  logic [CNT_W-1:0] thr_hi,
  input  logic [CNT_W-1:0] thr_lo,
  output logic             want_up,
  output logic             want_dn
);

  policy_e pol;
  logic    hi_single, hi_double, lo_single, lo_double;

  assign pol       = policy_e'(dbl_mode);
  assign hi_single = err_count >  thr_hi;
  assign hi_double = err_count >= thr_hi;
  assign lo_single = err_count <= thr_hi;
  assign lo_double = err_count <= thr_lo;

  always_comb begin
    if (pol == POL_DOUBLE) begin
      want_up = hi_double;
      want_dn = win_done & lo_double;
    end else begin
      want_up = hi_single;
      want_dn = win_done & lo_single;
    end
  end

endmodule

// File: rtl/vstep_code_reg.sv
module vstep_code_reg
  import vstep_pkg::*;
#(
  parameter int CODE_W = 7,
  parameter int VMIN   = 60,
  parameter int VMAX   = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_up,
  input  logic              go_dn,
  input  logic [1:0]        step_sel,
  output logic [CODE_W-1:0] vcode,
  output logic              at_max,
  output logic              at_min
);

  localparam logic [CODE_W:0] MAXW = (CODE_W+1)'(VMAX);
  localparam logic [CODE_W:0] MINW = (CODE_W+1)'(VMIN);

  function automatic logic [CODE_W-1:0] sat_add(input logic [CODE_W-1:0] c,
                                                 input logic [CODE_W:0] s);
    logic [CODE_W:0] sum;
    sum = {1'b0, c} + s;
    return (sum > MAXW) ? MAXW[CODE_W-1:0] : sum[CODE_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] sat_sub(input logic [CODE_W-1:0] c,
                                                 input logic [CODE_W:0] s);
    logic [CODE_W:0] diff;
    if ({1'b0, c} < MINW + s) return MINW[CODE_W-1:0];
    diff = {1'b0, c} - s;
    return diff[CODE_W-1:0];
  endfunction

  logic [CODE_W:0] stp;
  assign stp    = (CODE_W+1)'(step_units(step_sel));
  assign at_max = {1'b0, vcode} >= MAXW;
  assign at_min = {1'b0, vcode} <= MINW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vcode <= MAXW[CODE_W-1:0];
    else if (go_up) vcode <= sat_add(vcode, stp);
    else if (go_dn) vcode <= sat_sub(vcode, stp);
  end

endmodule

// File: rtl/vstep_settle.sv
module vstep_settle
  import vstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] step_sel,
  output logic       busy
);

  logic [LAT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= settle_cycles(step_sel);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = remain != '0;

endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
  import vstep_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CODE_W = 7,
  parameter int VMIN   = 60,
  parameter int VMAX   = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  err_count,
  input  logic              win_done,
  input  logic              dbl_mode,
  input  logic [CNT_W-1:0]  thr_hi,
  input  logic [CNT_W-1:0]  thr_lo,
  input  logic [1:0]        step_sel,
  output logic [CODE_W-1:0] vcode,
  output logic              step_up,
  output logic              step_dn,
  output logic              busy,
  output logic              win_restart
);

  // named decision events
  logic want_up, want_dn;
  logic at_max, at_min;
  logic ev_raise, ev_lower, ev_early;

  vstep_decide #(.CNT_W(CNT_W)) decide_i (
    .err_count (err_count),
    .win_done  (win_done),
    .dbl_mode  (dbl_mode),
    .thr_hi    (thr_hi),
    .thr_lo    (thr_lo),
    .want_up   (want_up),
    .want_dn   (want_dn)
  );

  // raise has priority; any request at a bound or while settling is dropped
  assign ev_raise = want_up & ~busy & ~at_max;
  assign ev_lower = want_dn & ~want_up & ~busy & ~at_min;
  assign ev_early = ev_raise & ~win_done;

  vstep_code_reg #(.CODE_W(CODE_W), .VMIN(VMIN), .VMAX(VMAX)) code_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_up    (ev_raise),
    .go_dn    (ev_lower),
    .step_sel (step_sel),
    .vcode    (vcode),
    .at_max   (at_max),
    .at_min   (at_min)
  );

  vstep_settle settle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_raise | ev_lower),
    .step_sel (step_sel),
    .busy     (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_up     <= 1'b0;
      step_dn     <= 1'b0;
      win_restart <= 1'b0;
    end else begin
      step_up     <= ev_raise;
      step_dn     <= ev_lower;
      win_restart <= ev_early;
    end
  end

endmodule

// File: rtl/vstep_ctrl_chk.sv
module vstep_ctrl_chk #(
  parameter int CODE_W = 7,
  parameter int VMIN   = 60,
  parameter int VMAX   = 110
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_done,
  input logic [CODE_W-1:0] vcode,
  input logic              step_up,
  input logic              step_dn,
  input logic              busy,
  input logic              win_restart
);

  assert_code_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vcode) >= VMIN) && (int'(vcode) <= VMAX));

  assert_up_raises_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> vcode > $past(vcode));

  assert_dn_lowers_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> vcode < $past(vcode));

  assert_code_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up || step_dn) |-> $stable(vcode));

  assert_step_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> !$past(busy));

  assert_busy_with_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> busy);

  assert_restart_mid_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_restart |-> (step_up && !$past(win_done)));

  assert_one_direction_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

endmodule

bind vstep_ctrl vstep_ctrl_chk #(.CODE_W(CODE_W), .VMIN(VMIN), .VMAX(VMAX)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_done    (win_done),
  .vcode       (vcode),
  .step_up     (step_up),
  .step_dn     (step_dn),
  .busy        (busy),
  .win_restart (win_restart)
);

// File: tb/vstep_ctrl_tb_top.sv
module vstep_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int CODE_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] err_count = '0;
  logic win_done = 1'b0;
  logic dbl_mode = 1'b0;
  logic [CNT_W-1:0] thr_hi = 16'd20;
  logic [CNT_W-1:0] thr_lo = 16'd4;
  logic [1:0] step_sel = 2'd0;
  logic [CODE_W-1:0] vcode;
  logic step_up, step_dn, busy, win_restart;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vstep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .err_count(err_count), .win_done(win_done),
    .dbl_mode(dbl_mode), .thr_hi(thr_hi), .thr_lo(thr_lo), .step_sel(step_sel),
    .vcode(vcode), .step_up(step_up), .step_dn(step_dn), .busy(busy),
    .win_restart(win_restart)
  );

  function automatic int stp_of(input int s);
    int t[4] = '{2, 5, 10, 25};
    return t[s];
  endfunction

  function automatic int lat_of(input int s);
    int t[4] = '{1, 2, 5, 12};
    return t[s];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  int m_code, m_wait;
  bit m_up, m_dn, m_rs;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code <= 110; m_wait <= 0; m_up <= 0; m_dn <= 0; m_rs <= 0;
    end else begin
      bit hi_ok, lo_ok;
      int c, s;
      c = int'(err_count);
      s = stp_of(int'(step_sel));
      hi_ok = dbl_mode ? (c >= int'(thr_hi)) : (c > int'(thr_hi));
      lo_ok = win_done && (dbl_mode ? (c <= int'(thr_lo)) : (c <= int'(thr_hi)));
      m_up <= 0; m_dn <= 0; m_rs <= 0;
      if (m_wait > 0) m_wait <= m_wait - 1;
      else if (hi_ok) begin
        if (m_code < 110) begin
          m_code <= (m_code + s > 110) ? 110 : m_code + s;
          m_up <= 1; m_rs <= !win_done; m_wait <= lat_of(int'(step_sel));
        end
      end else if (lo_ok) begin
        if (m_code > 60) begin
          m_code <= (m_code - s < 60) ? 60 : m_code - s;
          m_dn <= 1; m_wait <= lat_of(int'(step_sel));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && !done) begin
      check(int'(vcode) == m_code, "R6 R9 vcode", int'(vcode), m_code);
      check(step_up == m_up, "R2 R4 R10 step_up", int'(step_up), int'(m_up));
      check(step_dn == m_dn, "R3 R5 step_dn", int'(step_dn), int'(m_dn));
      check(busy == (m_wait != 0), "R7 busy", int'(busy), int'(m_wait != 0));
      check(win_restart == m_rs, "R8 win_restart", int'(win_restart), int'(m_rs));
    end
  end

  task automatic quiet();
    err_count = '0; win_done = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40 && busy; k++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int nb;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vcode == 7'd110, "R1 reset vcode", int'(vcode), 110);
    check(!step_up && !step_dn, "R1 reset pulses", int'(step_up | step_dn), 0);
    check(!busy && !win_restart, "R1 reset busy/restart", int'(busy | win_restart), 0);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R3 R6: single mode, lower by 25 at window close
    dbl_mode = 0; thr_hi = 20; step_sel = 3; err_count = 0; win_done = 1;
    @(negedge clk); quiet();
    check(step_dn && vcode == 7'd85, "R3 R6 lower by 25", int'(vcode), 85);
    nb = 0;
    for (int k = 0; k < 40 && busy; k++) begin nb++; @(negedge clk); end
    check(nb == 12, "R7 settle 12 cycles", nb, 12);
    win_done = 1; @(negedge clk); quiet(); wait_idle();
    check(vcode == 7'd60, "R9 at lower bound", int'(vcode), 60);
    win_done = 1; @(negedge clk); quiet();
    check(!step_dn && !busy && vcode == 7'd60, "R9 drop at bound", int'(vcode), 60);

    // R2: equal count does not raise, one above does
    step_sel = 0; err_count = 20; @(negedge clk);
    check(!step_up, "R2 equal no raise", int'(step_up), 0);
    err_count = 21; @(negedge clk); quiet();
    check(step_up && vcode == 7'd62, "R2 R6 raise by 2", int'(vcode), 62);
    check(win_restart, "R8 restart mid-window", int'(win_restart), 1);
    nb = 0;
    for (int k = 0; k < 40 && busy; k++) begin nb++; @(negedge clk); end
    check(nb == 1, "R7 settle 1 cycle", nb, 1);

    // R5: double mode neutral band, then lower with saturation
    dbl_mode = 1; thr_hi = 20; thr_lo = 4; step_sel = 1;
    err_count = 10; win_done = 1; @(negedge clk); quiet();
    check(!step_dn && !step_up && vcode == 7'd62, "R5 neutral band", int'(vcode), 62);
    err_count = 4; win_done = 1; @(negedge clk); quiet();
    check(step_dn && vcode == 7'd60, "R5 R9 lower saturates", int'(vcode), 60);
    wait_idle();
    // R4: equal count raises in double mode
    err_count = 20; @(negedge clk); quiet();
    check(step_up && vcode == 7'd65, "R4 raise at equal", int'(vcode), 65);
    wait_idle();
    err_count = 20; win_done = 1; @(negedge clk); quiet();
    check(step_up && !win_restart, "R8 no restart at close", int'(win_restart), 0);
    wait_idle();
    // R10: crossed thresholds, raise wins
    thr_lo = 30; err_count = 25; win_done = 1; @(negedge clk); quiet();
    check(step_up && !step_dn && vcode == 7'd75, "R10 raise priority", int'(vcode), 75);
    wait_idle();
    // R9: upper bound
    thr_lo = 4; step_sel = 3; err_count = 100; @(negedge clk); quiet(); wait_idle();
    err_count = 100; @(negedge clk); quiet();
    check(vcode == 7'd110, "R9 raise saturates", int'(vcode), 110);
    wait_idle();
    err_count = 100; @(negedge clk); quiet();
    check(!step_up && !win_restart && !busy, "R9 drop at top", int'(step_up), 0);

    // constrained random phase, checked by the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) begin
        dbl_mode = 1'($urandom_range(0, 1));
        step_sel = 2'($urandom_range(0, 3));
        thr_hi = 16'($urandom_range(0, 40));
        thr_lo = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(0, 40)) : thr_hi / 5;
      end
      err_count = 16'($urandom_range(0, 50));
      win_done = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    quiet();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule